// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

The controller watches an 8-bit temperature code from an on-die sensor. It compares that code against three programmable heating levels and three programmable cooling levels. Each heating level sets a sticky status bit while the code is at or above its limit. Each cooling level sets a sticky status bit when the code drops below its limit after having reached it. Software reads the status, masks it through an enable register and clears it by writing ones. A single interrupt line carries any enabled status bit.

The highest heating level also drives a hardware shutdown request. Once the core and the shutdown enable are both on and the code reaches that level, the request latches and stays asserted until reset. The sensor, its trim storage and the power controller lie outside the block.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x10008802, and the interrupt enable and status registers read 0. The interrupt and trip outputs are low.
- R2: A register write takes effect at the clock edge where `reg_we` is high. Register addresses are: 0 control, 1 heating limits, 2 cooling limits, 3 interrupt enable, 4 status, 5 clear, 6 current code. Address 7 reads 0. In both limit registers, level n occupies bits [8n+15:8n+8] and bits [7:0] read 0. The enable register keeps only bits 0, 4, 8, 16, 20 and 24. The clear register reads 0.
- R3: Heating status for level n sits at status bit 4n. It sets at the first clock edge where control bit 0 (core enable) is 1 and the code is at or above that level's heating limit.
- R4: Cooling status for level n sits at status bit 16+4n. A level arms at an edge where the core is enabled and the code is at or above its cooling limit. The status bit sets at an edge where the level is armed, the core is enabled and the code is below the limit. This event disarms the level. Without arming, a low code sets nothing.
- R5: While the core enable is 0, no status bit sets and every cooling level disarms.
- R6: Writing 1 to a status bit position at address 5 clears that bit. Writing 0 leaves it unchanged. If the set condition holds in the same cycle, the bit stays set.
- R7: `irq` is high exactly when some status bit is set together with the same bit of the interrupt enable register.
- R8: `thermal_trip` latches high at the edge where control bit 0 and control bit 12 are both 1 and the code is at or above the level-2 heating limit. It stays high until reset and never rises while bit 12 is 0.
- R9: Address 6 returns the live temperature code in bits [7:0] with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| temp_code | input | 8 | Sensed temperature code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined enabled interrupt |
| thermal_trip | output | 1 | Latched hardware shutdown request |

## Verification
The bench clears a heating bit while the code is still above its limit. A design that lets the clear win would lose an event that is still active. It cools the code below the cooling limits with and without prior arming. A design that skipped arming would flag cooling events after a cold power-up. It sweeps the code high with the core disabled and with the shutdown enable off. A design that ignored either enable would set status or trip without permission. It then lowers the code and drops the enables after a trip. A design with a level-following trip output would release the shutdown.

// File: rtl/tti_pkg.sv
package tti_pkg;
   localparam int DATA_W      = 32;
   localparam int ADDR_W      = 3;
   localparam int MAX_LVL     = 3;
   localparam int CORE_EN_BIT = 0;
   localparam int TRIP_EN_BIT = 12;
   localparam logic [DATA_W-1:0] CTRL_RST = 32'h1000_8802;

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL  = 3'd0,
      A_HEAT  = 3'd1,
      A_COOL  = 3'd2,
      A_INTEN = 3'd3,
      A_STAT  = 3'd4,
      A_CLR   = 3'd5,
      A_TEMP  = 3'd6,
      A_NONE  = 3'd7
   } addr_e;

   // status / enable / clear bit for a heating level
   function automatic int heat_pos(input int lvl);
      return 4 * lvl;
   endfunction

   // status / enable / clear bit for a cooling level
   function automatic int cool_pos(input int lvl);
      return 16 + 4 * lvl;
   endfunction

   // lowest bit of a level's code inside a packed limit register
   function automatic int thr_lsb(input int lvl);
      return 8 + 8 * lvl;
   endfunction

   function automatic logic [DATA_W-1:0] evt_mask(input int nlvl);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < nlvl; i++) begin
         m[heat_pos(i)] = 1'b1;
         m[cool_pos(i)] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [DATA_W-1:0] thr_mask(input int nlvl, input int cw);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < nlvl; i++)
         for (int b = 0; b < cw; b++)
            m[thr_lsb(i) + b] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/tti_level.sv
module tti_level #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_en,
   input  logic [CODE_W-1:0] temp,
   input  logic [CODE_W-1:0] heat_thr,
   input  logic [CODE_W-1:0] cool_thr,
   input  logic              clr_heat,
   input  logic              clr_cool,
   output logic              heat_st,
   output logic              cool_st
);
   logic armed_q;
   logic heat_hit;
   logic cool_hit;

   assign heat_hit = core_en && (temp >= heat_thr);
   assign cool_hit = core_en && armed_q && (temp < cool_thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         heat_st <= 1'b0;
         cool_st <= 1'b0;
      end else begin
         heat_st <= (heat_st && !clr_heat) || heat_hit;
         cool_st <= (cool_st && !clr_cool) || cool_hit;
         if (!core_en)
            armed_q <= 1'b0;
         else if (temp >= cool_thr)
            armed_q <= 1'b1;
         else if (cool_hit)
            armed_q <= 1'b0;
      end
   end
endmodule

// File: rtl/tti_trip.sv
module tti_trip (
   input  logic clk,
   input  logic rst_n,
   input  logic allow,
   input  logic hot,
   output logic trip
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         trip <= 1'b0;
      else if (allow && hot)
         trip <= 1'b1;
   end
endmodule

// File: rtl/tti_regs.sv
module tti_regs
   import tti_pkg::*;
#(
   parameter int LVL_N  = 3,
   parameter int CODE_W = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         we,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic [DATA_W-1:0]            stat,
   input  logic [CODE_W-1:0]            temp,
   output logic [DATA_W-1:0]            rdata,
   output logic                         core_en,
   output logic                         trip_en,
   output logic [LVL_N-1:0][CODE_W-1:0] heat_thr,
   output logic [LVL_N-1:0][CODE_W-1:0] cool_thr,
   output logic [DATA_W-1:0]            inten,
   output logic [LVL_N-1:0]             clr_heat,
   output logic [LVL_N-1:0]             clr_cool
);
   localparam logic [DATA_W-1:0] EVT_M = evt_mask(LVL_N);
   localparam logic [DATA_W-1:0] THR_M = thr_mask(LVL_N, CODE_W);

   addr_e             a;
   logic [DATA_W-1:0] ctrl_q, heat_q, cool_q, inten_q;
   logic              clr_wr;

   assign a      = addr_e'(addr);
   assign clr_wr = we && (a == A_CLR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         heat_q  <= '0;
         cool_q  <= '0;
         inten_q <= '0;
      end else if (we) begin
         case (a)
            A_CTRL:  ctrl_q  <= wdata;
            A_HEAT:  heat_q  <= wdata & THR_M;
            A_COOL:  cool_q  <= wdata & THR_M;
            A_INTEN: inten_q <= wdata & EVT_M;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (a)
         A_CTRL:  rdata = ctrl_q;
         A_HEAT:  rdata = heat_q;
         A_COOL:  rdata = cool_q;
         A_INTEN: rdata = inten_q;
         A_STAT:  rdata = stat;
         A_TEMP:  rdata = {{(DATA_W-CODE_W){1'b0}}, temp};
         default: rdata = '0;
      endcase
   end

   assign core_en = ctrl_q[CORE_EN_BIT];
   assign trip_en = ctrl_q[TRIP_EN_BIT];
   assign inten   = inten_q;

   for (genvar i = 0; i < LVL_N; i++) begin : g_fld
      assign heat_thr[i] = heat_q[thr_lsb(i) +: CODE_W];
      assign cool_thr[i] = cool_q[thr_lsb(i) +: CODE_W];
      assign clr_heat[i] = clr_wr && wdata[heat_pos(i)];
      assign clr_cool[i] = clr_wr && wdata[cool_pos(i)];
   end
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
   import tti_pkg::*;
#(
   parameter int LVL_N  = 3,
   parameter int CODE_W = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  temp_code,
   input  logic        reg_we,
   input  logic [2:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        irq,
   output logic        thermal_trip
);
   localparam int TOP_LVL = LVL_N - 1;

   if (LVL_N < 1 || LVL_N > MAX_LVL) begin : g_bad_lvl
      $error("LVL_N must lie in 1..3");
   end
   if (CODE_W != 8) begin : g_bad_code
      $error("CODE_W must be 8 to fit the packed limit fields");
   end

   logic                         core_en, trip_en;
   logic [LVL_N-1:0][CODE_W-1:0] heat_thr, cool_thr;
   logic [DATA_W-1:0]            inten_q;
   logic [LVL_N-1:0]             clr_heat, clr_cool;
   logic [LVL_N-1:0]             heat_st, cool_st;
   logic [DATA_W-1:0]            stat_v;

   tti_regs #(.LVL_N(LVL_N), .CODE_W(CODE_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .stat     (stat_v),
      .temp     (temp_code),
      .rdata    (reg_rdata),
      .core_en  (core_en),
      .trip_en  (trip_en),
      .heat_thr (heat_thr),
      .cool_thr (cool_thr),
      .inten    (inten_q),
      .clr_heat (clr_heat),
      .clr_cool (clr_cool)
   );

   for (genvar i = 0; i < LVL_N; i++) begin : g_lvl
      tti_level #(.CODE_W(CODE_W)) u_lvl (
         .clk      (clk),
         .rst_n    (rst_n),
         .core_en  (core_en),
         .temp     (temp_code),
         .heat_thr (heat_thr[i]),
         .cool_thr (cool_thr[i]),
         .clr_heat (clr_heat[i]),
         .clr_cool (clr_cool[i]),
         .heat_st  (heat_st[i]),
         .cool_st  (cool_st[i])
      );
   end

   always_comb begin
      stat_v = '0;
      for (int i = 0; i < LVL_N; i++) begin
         stat_v[heat_pos(i)] = heat_st[i];
         stat_v[cool_pos(i)] = cool_st[i];
      end
   end

   assign irq = |(stat_v & inten_q);

   tti_trip u_trip (
      .clk   (clk),
      .rst_n (rst_n),
      .allow (core_en && trip_en),
      .hot   (temp_code >= heat_thr[TOP_LVL]),
      .trip  (thermal_trip)
   );
endmodule

// File: rtl/tti_checker.sv
module tti_checker #(
   parameter int LVL_N  = 3,
   parameter int CODE_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CODE_W-1:0]            temp_code,
   input logic                         irq,
   input logic                         thermal_trip,
   input logic                         core_en,
   input logic                         trip_en,
   input logic [LVL_N-1:0][CODE_W-1:0] heat_thr,
   input logic [31:0]                  stat,
   input logic [31:0]                  inten
);
   AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      thermal_trip |=> thermal_trip); // R8

   AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thermal_trip) |-> $past(core_en && trip_en && (temp_code >= heat_thr[LVL_N-1]))); // R8

   AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!core_en) |-> ((stat & ~$past(stat)) == 32'd0)); // R5

   AST_HEAT_L0_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(core_en && (temp_code >= heat_thr[0])) |-> stat[0]); // R3

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat & inten) == 32'd0) |-> !irq); // R7
endmodule

bind thermal_irq_ctrl tti_checker #(.LVL_N(LVL_N), .CODE_W(CODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .temp_code    (temp_code),
   .irq          (irq),
   .thermal_trip (thermal_trip),
   .core_en      (core_en),
   .trip_en      (trip_en),
   .heat_thr     (heat_thr),
   .stat         (stat_v),
   .inten        (inten_q)
);

// File: tb/sim_thermal_irq_ctrl.sv
`timescale 1ns/1ps
module sim_thermal_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  temp = 8'd0;
   logic        we = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        irq, trip;

   int checks = 0;
   int errors = 0;
   bit live = 1'b0;

   always #2 clk = ~clk;

   thermal_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .temp_code(temp), .reg_we(we),
      .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
      .irq(irq), .thermal_trip(trip)
   );

   // behavioural reference
   logic [31:0] m_ctrl, m_heat, m_cool, m_inten, m_stat, m_nxt;
   bit          m_arm[3];
   bit          m_trip;
   int          lim_h, lim_c;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 32'h1000_8802; m_heat = 0; m_cool = 0; m_inten = 0;
         m_stat = 0; m_trip = 0;
         foreach (m_arm[k]) m_arm[k] = 0;
      end else begin
         m_nxt = m_stat;
         if (we && addr == 3'd5) m_nxt = m_nxt & ~(wdata & 32'h0111_0111);
         for (int i = 0; i < 3; i++) begin
            lim_h = (m_heat >> (8 + 8*i)) & 255;
            lim_c = (m_cool >> (8 + 8*i)) & 255;
            if (m_ctrl[0] && temp >= lim_h) m_nxt[4*i] = 1'b1;
            if (!m_ctrl[0]) m_arm[i] = 0;
            else if (temp >= lim_c) m_arm[i] = 1;
            else if (m_arm[i]) begin
               m_nxt[16 + 4*i] = 1'b1;
               m_arm[i] = 0;
            end
         end
         lim_h = (m_heat >> 24) & 255;
         if (m_ctrl[0] && m_ctrl[12] && temp >= lim_h) m_trip = 1;
         m_stat = m_nxt;
         if (we) begin
            case (addr)
               3'd0: m_ctrl  = wdata;
               3'd1: m_heat  = wdata & 32'hFFFF_FF00;
               3'd2: m_cool  = wdata & 32'hFFFF_FF00;
               3'd3: m_inten = wdata & 32'h0111_0111;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [31:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_ctrl;
         3'd1: return m_heat;
         3'd2: return m_cool;
         3'd3: return m_inten;
         3'd4: return m_stat;
         3'd6: return {24'd0, temp};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (live && rst_n) begin
         check("R7 irq per cycle", {31'd0, irq}, {31'd0, |(m_stat & m_inten)});
         check("R8 trip per cycle", {31'd0, trip}, {31'd0, m_trip});
         check("R2 R3 R4 R9 read per cycle", rdata, m_read(addr));
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0; wdata = 32'd0;
   endtask
   task automatic set_t(input int t);
      @(negedge clk); temp = 8'(t);
   endtask
   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); addr = a; #1;
      check(tag, rdata, exp);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1; live = 1'b1;
      // R1 reset state
      rd(3'd0, 32'h1000_8802, "R1 control reset");
      rd(3'd3, 32'd0, "R1 enable reset");
      rd(3'd4, 32'd0, "R1 status reset");
      check("R1 irq reset", {31'd0, irq}, 32'd0);
      check("R1 trip reset", {31'd0, trip}, 32'd0);
      // R2 configuration: heat 95/105/110, cool 80/90/100
      wr(3'd1, 32'h6E69_5FAB);
      wr(3'd2, 32'h645A_50CD);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd0, 32'h1000_8803);
      rd(3'd1, 32'h6E69_5F00, "R2 heat limits low byte zero");
      rd(3'd3, 32'h0111_0111, "R2 enable masked");
      rd(3'd5, 32'd0, "R2 clear reads zero");
      rd(3'd7, 32'd0, "R2 spare reads zero");
      // R3 heat ramp without trip enable
      for (int t = 70; t <= 115; t += 5) begin set_t(t); idle(1); end
      idle(2);
      rd(3'd4, 32'h0000_0111, "R3 all heating levels set");
      check("R8 no trip with enable off", {31'd0, trip}, 32'd0);
      check("R7 irq high", {31'd0, irq}, 32'd1);
      // R6 clear while still hot keeps bits
      wr(3'd5, 32'h0000_0111);
      rd(3'd4, 32'h0000_0111, "R6 set wins over clear");
      // R4 cooling events
      set_t(60); idle(2);
      rd(3'd4, 32'h0111_0111, "R4 cooling levels set");
      wr(3'd5, 32'h0000_0001);
      rd(3'd4, 32'h0111_0110, "R6 single clear");
      wr(3'd5, 32'h0000_0000);
      rd(3'd4, 32'h0111_0110, "R6 zero write no effect");
      wr(3'd5, 32'h0111_0110);
      rd(3'd4, 32'd0, "R6 clear all");
      check("R7 irq low when clear", {31'd0, irq}, 32'd0);
      // R4 no arming from cold
      set_t(40); idle(3);
      rd(3'd4, 32'd0, "R4 no cooling event without arming");
      // R7 masking
      wr(3'd3, 32'h0000_0010);
      set_t(100); idle(2);
      rd(3'd4, 32'h0000_0001, "R3 only level0 set at 100");
      check("R7 masked status gives no irq", {31'd0, irq}, 32'd0);
      set_t(106); idle(2);
      check("R7 enabled level1 raises irq", {31'd0, irq}, 32'd1);
      // R5 core disabled
      wr(3'd0, 32'h1000_8802);
      wr(3'd5, 32'h0111_0111);
      set_t(120); idle(2);
      rd(3'd4, 32'd0, "R5 no set with core off");
      set_t(50); idle(2);
      rd(3'd4, 32'd0, "R5 no cooling event with core off");
      wr(3'd0, 32'h1000_8803); idle(2);
      rd(3'd4, 32'd0, "R5 disarmed after core off");
      // R8 trip
      wr(3'd0, 32'h1000_9803);
      set_t(109); idle(2);
      check("R8 no trip below level2", {31'd0, trip}, 32'd0);
      set_t(112); idle(2);
      check("R8 trip raised", {31'd0, trip}, 32'd1);
      set_t(30);
      wr(3'd0, 32'h1000_8802); idle(2);
      check("R8 trip sticky", {31'd0, trip}, 32'd1);
      // R9 live code
      rd(3'd6, 32'h0000_001E, "R9 temperature read");
      set_t(8'hA5);
      rd(3'd6, 32'h0000_00A5, "R9 temperature follows input");
      idle(2);
      live = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule